// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block shapes the active-low read and write strobes for one ATA device channel during programmed-I/O and multiword-DMA style cycles. A 32-bit timing word held inside the block gives all durations in bus-clock cycles. Data-port accesses and task-file register accesses each have their own active time, inactive time and first-cycle setup time. Every field is counted as its value plus one cycles.

A request starts a burst of one or more strobe cycles. The burst begins with a setup phase in which both strobes stay high. It then alternates between an active phase, with the selected strobe low, and an inactive phase, with the strobe high. A single-cycle done pulse ends the burst. The timing word is loaded through a masked write port. The transfer-mode selector decides which bit fields a write may replace.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is asserted and right after it, both strobes are high, done_o is low and cfg_word_o equals the parameter RESET_WORD (default 32'h0D029D5E).
- R2: For a data access (task_i=0), the strobe is low for word[8:4]+1 cycles and then high for word[3:0]+1 cycles per transfer cycle.
- R3: For a task-file access (task_i=1), the strobe is low for word[17:13]+1 cycles and then high for word[12:9]+1 cycles per transfer cycle.
- R4: A burst begins with a setup phase of word[24:22]+1 cycles for data accesses, or word[27:25]+1 cycles for task-file accesses. During this phase both strobes are high. The phase starts in the cycle after start_i is sampled.
- R5: With write_i=1 only diow_no goes low, and with write_i=0 only dior_no goes low. The two strobes are never low together.
- R6: A burst holds len_i+1 transfer cycles. Each inactive phase except the last is followed directly by the next active phase, with no further setup.
- R7: done_o is high for exactly one cycle, the cycle after the last inactive cycle. The block accepts a new start in the cycle after that.
- R8: A start_i that is sampled during setup, active, inactive or done cycles is ignored.
- R9: The timing word, task_i, write_i and len_i are captured when a burst starts. A configuration write during the burst does not change that burst.
- R10: A write with cfg_we_i=1 replaces only the bits under the mask chosen by cfg_mode_i: 0 (PIO) 32'hCFC3FFFF, 1 (multiword DMA) 32'h31C001FF, 2 (UDMA) 32'h303C0000, 3 no bits. The new word appears on cfg_word_o in the next cycle.
- R11: When no burst is in progress, both strobes are high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Masked write enable for the timing word |
| cfg_mode_i | input | 2 | Mode that selects the write mask |
| cfg_wdata_i | input | 32 | Write data for the timing word |
| cfg_word_o | output | 32 | Current stored timing word |
| start_i | input | 1 | Burst start request |
| task_i | input | 1 | 1: task-file register access, 0: data access |
| write_i | input | 1 | 1: write strobe, 0: read strobe |
| len_i | input | LEN_W | Number of transfer cycles minus one |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The assertions assume that start_i, cfg_we_i and the data inputs change only between clock edges and are defined once reset is released. They also assume that cfg_mode_i is valid whenever cfg_we_i is high. The stimulus drives every input on the falling edge and holds it for a full cycle. It raises start_i in idle, busy and done cycles, and issues masked writes in every mode, both between bursts and in the middle of a burst. A reference model follows the accepted bursts and the stored word. It is compared against the strobes, done_o and cfg_word_o on every cycle.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {
    MODE_PIO   = 2'd0,
    MODE_MWDMA = 2'd1,
    MODE_UDMA  = 2'd2,
    MODE_NONE  = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ACT, PH_INACT, PH_DONE
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] pre;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] inact;
  } strobe_timing_t;

  localparam logic [WORD_W-1:0] MASK_PIO   = 32'hCFC3_FFFF;
  localparam logic [WORD_W-1:0] MASK_MWDMA = 32'h31C0_01FF;
  localparam logic [WORD_W-1:0] MASK_UDMA  = 32'h303C_0000;

  function automatic logic [WORD_W-1:0] mode_mask(input logic [1:0] mode);
    case (mode)
      MODE_PIO:   return MASK_PIO;
      MODE_MWDMA: return MASK_MWDMA;
      MODE_UDMA:  return MASK_UDMA;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_strobe_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = 32'h0D02_9D5E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] mask;
  assign mask = mode_mask(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= RESET_WORD;
    else if (we_i) word_o <= (word_o & ~mask) | (wdata_i & mask);
  end
endmodule

// File: rtl/pio_field_sel.sv
module pio_field_sel
  import pio_strobe_pkg::*;
(
  input  logic              task_i,
  input  logic [WORD_W-1:0] word_i,
  output strobe_timing_t    tim_o
);
  always_comb begin
    if (task_i) begin
      tim_o.pre   = CNT_W'(word_i[27:25]);
      tim_o.act   = CNT_W'(word_i[17:13]);
      tim_o.inact = CNT_W'(word_i[12:9]);
    end else begin
      tim_o.pre   = CNT_W'(word_i[24:22]);
      tim_o.act   = CNT_W'(word_i[8:4]);
      tim_o.inact = CNT_W'(word_i[3:0]);
    end
  end
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_strobe_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              task_i,
  input  logic              write_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dior_no,
  output logic              diow_no,
  output logic              done_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  left_q;
  logic [WORD_W-1:0] snap_q;
  logic              task_q, write_q;
  strobe_timing_t    tim;

  pio_field_sel u_sel (
    .task_i (task_q),
    .word_i (snap_q),
    .tim_o  (tim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      snap_q  <= '0;
      task_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          // capture everything so later config writes cannot disturb the burst
          phase_q <= PH_SETUP;
          cnt_q   <= '0;
          left_q  <= len_i;
          snap_q  <= word_i;
          task_q  <= task_i;
          write_q <= write_i;
        end
        PH_SETUP: begin
          if (cnt_q == tim.pre) begin
            phase_q <= PH_ACT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_ACT: begin
          if (cnt_q == tim.act) begin
            phase_q <= PH_INACT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_INACT: begin
          if (cnt_q == tim.inact) begin
            cnt_q <= '0;
            if (left_q == '0) phase_q <= PH_DONE;
            else begin
              phase_q <= PH_ACT;
              left_q  <= left_q - 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign dior_no = !((phase_q == PH_ACT) && !write_q);
  assign diow_no = !((phase_q == PH_ACT) &&  write_q);
  assign done_o  = (phase_q == PH_DONE);
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int                LEN_W      = 4,
  parameter logic [WORD_W-1:0] RESET_WORD = 32'h0D02_9D5E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_word_o,
  input  logic              start_i,
  input  logic              task_i,
  input  logic              write_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              dior_no,
  output logic              diow_no,
  output logic              done_o
);
  pio_cfg_reg #(.RESET_WORD(RESET_WORD)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .mode_i  (cfg_mode_i),
    .wdata_i (cfg_wdata_i),
    .word_o  (cfg_word_o)
  );

  pio_strobe_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .task_i  (task_i),
    .write_i (write_i),
    .len_i   (len_i),
    .word_i  (cfg_word_o),
    .dior_no (dior_no),
    .diow_no (diow_no),
    .done_o  (done_o)
  );
endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [1:0]  cfg_mode_i,
  input logic [31:0] cfg_word_o,
  input logic        dior_no,
  input logic        diow_no,
  input logic        done_o
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dior_no || diow_no);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_strobe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dior_no && diow_no));

  // R10
  no_mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd3) |=> $stable(cfg_word_o));

  // R10
  idle_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_word_o));

  // R10
  pio_keep_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i == 2'd0) |=>
      ((cfg_word_o ^ $past(cfg_word_o)) & ~32'hCFC3_FFFF) == 32'h0);
endmodule

bind pio_strobe_gen pio_strobe_gen_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_mode_i (cfg_mode_i),
  .cfg_word_o (cfg_word_o),
  .dior_no    (dior_no),
  .diow_no    (diow_no),
  .done_o     (done_o)
);

// File: tb/test_pio_strobe_gen.sv
`timescale 1ns/1ps
module test_pio_strobe_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_mode_i = 2'd0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_word_o;
  logic        start_i = 1'b0, task_i = 1'b0, write_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic        dior_no, diow_no, done_o;

  int checks = 0;
  int errors = 0;
  bit [31:0] model_word = 32'h0D02_9D5E;
  bit [2:0]  exp_q[$];   // {dior_no, diow_no, done_o}
  string     tag_q[$];

  always #10 clk_i = ~clk_i;

  pio_strobe_gen i_pio_strobe_gen (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_mode_i, .cfg_wdata_i, .cfg_word_o,
    .start_i, .task_i, .write_i, .len_i, .dior_no, .diow_no, .done_o
  );

  // R10 masks per mode
  function automatic bit [31:0] bench_mask(input bit [1:0] m);
    if (m == 2'd0) return 32'hCFC3_FFFF;
    if (m == 2'd1) return 32'h31C0_01FF;
    if (m == 2'd2) return 32'h303C_0000;
    return 32'h0;
  endfunction

  task automatic push_burst(input bit tk, input bit wr, input int len);
    int pre, act, ina;
    string t;
    pre = tk ? int'(model_word[27:25]) : int'(model_word[24:22]);
    act = tk ? int'(model_word[17:13]) : int'(model_word[8:4]);
    ina = tk ? int'(model_word[12:9])  : int'(model_word[3:0]);
    t = tk ? "R3" : "R2";
    for (int i = 0; i <= pre; i++) begin exp_q.push_back(3'b110); tag_q.push_back("R4"); end
    for (int b = 0; b <= len; b++) begin
      for (int i = 0; i <= act; i++) begin
        exp_q.push_back(wr ? 3'b100 : 3'b010); tag_q.push_back(t);
      end
      for (int i = 0; i <= ina; i++) begin exp_q.push_back(3'b110); tag_q.push_back(t); end
    end
    exp_q.push_back(3'b111); tag_q.push_back("R7");
  endtask

  task automatic step(input bit st, input bit tk, input bit wr, input int len,
                      input bit we, input bit [1:0] md, input bit [31:0] wd,
                      input string note);
    bit [2:0] e;
    string tg;
    int sz;
    @(negedge clk_i);
    sz = exp_q.size();
    if (sz > 0) begin e = exp_q.pop_front(); tg = tag_q.pop_front(); end
    else begin e = 3'b110; tg = "R11"; end
    checks++;
    if ({dior_no, diow_no, done_o} !== e) begin
      errors++;
      $display("FAIL %s (%s) strobes/done actual=%b expected=%b", tg, note,
               {dior_no, diow_no, done_o}, e);
    end
    checks++;
    if (cfg_word_o !== model_word) begin
      errors++;
      $display("FAIL R10 (%s) cfg_word actual=%h expected=%h", note, cfg_word_o, model_word);
    end
    if (st && sz == 0) push_burst(tk, wr, len);  // R8: otherwise ignored
    if (we) model_word = (model_word & ~bench_mask(md)) | (wd & bench_mask(md));
    start_i = st; task_i = tk; write_i = wr; len_i = 4'(len);
    cfg_we_i = we; cfg_mode_i = md; cfg_wdata_i = wd;
  endtask

  task automatic drain(input string note);
    while (exp_q.size() > 0) step(0, 0, 0, 0, 0, 0, 0, note);
    step(0, 0, 0, 0, 0, 0, 0, note);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    checks++;
    if ({dior_no, diow_no, done_o} !== 3'b110 || cfg_word_o !== 32'h0D02_9D5E) begin
      errors++;
      $display("FAIL R1 actual=%b/%h expected=110/0d029d5e",
               {dior_no, diow_no, done_o}, cfg_word_o);
    end
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");

    // R2 R4 R5 single data read with reset word
    step(1, 0, 0, 0, 0, 0, 0, "R2 data read");
    drain("R2 data read");

    // R5 R6 data write burst of 3 cycles
    step(1, 0, 1, 2, 0, 0, 0, "R6 write burst");
    drain("R6 write burst");

    // R10 PIO mask write, then R3 task-file read
    step(0, 0, 0, 0, 1, 2'd0, 32'h0C82_9C62, "R10 pio write");
    step(1, 1, 0, 1, 0, 0, 0, "R3 task read");
    drain("R3 task read");

    // R8 start held high through burst and done cycle
    step(1, 0, 0, 1, 0, 0, 0, "R8 held start");
    for (int i = 0; i < 60; i++) step(1, 1, 1, 0, 0, 0, 0, "R8 held start");
    drain("R8 held start");

    // R9 config writes in the middle of a burst
    step(1, 1, 1, 2, 0, 0, 0, "R9 snapshot");
    step(0, 0, 0, 0, 1, 2'd0, 32'h0000_0000, "R9 snapshot");
    step(0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R9 snapshot");
    drain("R9 snapshot");

    // R10 other modes, including the no-update mode
    step(0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R10 udma write");
    step(0, 0, 0, 0, 1, 2'd3, 32'h0000_0000, "R10 none write");
    step(0, 0, 0, 0, 1, 2'd1, 32'h2C82_9D2E, "R10 mwdma write");
    step(0, 0, 0, 0, 0, 0, 0, "R10 settle");
    // R4 R2 burst with new data timing
    step(1, 0, 0, 3, 0, 0, 0, "R4 new timing");
    drain("R4 new timing");
    step(0, 0, 0, 0, 1, 2'd0, 32'h0000_0000, "R6 zero timing");
    step(1, 0, 1, 15, 0, 0, 0, "R6 min timing long burst");
    drain("R6 min timing long burst");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule